// File: doc/BRIEF.md
# Exception Arbiter and Status Bank

This block decides, on every clock, whether the processor must enter an exception, and it performs the state changes that entry and return require. It holds the current status word and one saved status word for each of the five exception modes. Pending requests (data abort, FIQ, IRQ, prefetch abort, undefined instruction, software interrupt) are filtered through the current interrupt mask bits and ranked by fixed priority. The winner moves the status into its mode, captures the old status in that mode's saved slot, and issues a PC redirect and a link-register write carrying the next-instruction address. Release of reset is handled as the highest class and enters supervisor mode at the base vector.

A return command copies the saved status of the current mode back into the current status. This restores the previous mode, mask bits and instruction-set state. A status write port lets software change the condition flags and, in privileged modes, the mask and mode fields. The redirect and link outputs are single-cycle valid pulses with no ready input. The consumer, the fetch and register-file logic, must accept every pulse in the cycle it appears, because exception entry cannot be stalled.

Top module: `exc_ctrl`

## Requirements
- R1: While `rst_n` is low, `psr_o` reads 0x000000D3: mode 10011 (supervisor), I (bit 7) and F (bit 6) set, T (bit 5) clear, flags clear, and no pulse is issued. At the first clock edge after release, the block enters supervisor mode at vector VEC_BASE+0x00, taking priority over every other request.
- R2: Among unmasked requests, the one taken is the highest in this order: reset release, data abort, FIQ, IRQ, prefetch abort, undefined instruction, software interrupt.
- R3: A FIQ request is ignored while F is 1, and an IRQ request is ignored while I is 1. A masked request issues no pulse and leaves the status unchanged.
- R4: On entry, `lr_we` pulses for one cycle with `lr_mode` set to the target mode code and `lr_data` equal to the `next_pc` value sampled at the entry edge.
- R5: On entry, the saved status slot of the target mode receives the status word as it stood before the entry edge.
- R6: On entry, the mode field becomes the target mode: svc 10011 for reset and software interrupt, abt 10111 for both aborts, und 11011 for undefined, irq 10010 for IRQ, fiq 10001 for FIQ. T is cleared and I is set. F is set only for reset and FIQ and is otherwise held. The flags (bits 31:28) are held.
- R7: `pc_vec` is VEC_BASE plus an offset: 0x00 reset, 0x04 undefined, 0x08 software interrupt, 0x0C prefetch abort, 0x10 data abort, 0x18 IRQ, 0x1C FIQ.
- R8: A return command with no entry copies the current mode's saved status into the status word, T included. In user (10000) or system (11111) mode, which have no saved slot, the command has no effect.
- R9: When an entry and a return command occur in the same cycle, the entry is performed and the return is dropped.
- R10: A status write with `psr_sel`=0 always updates bits 31:28. It updates I, F and M[4:0] only when the current mode is not user and the written mode is one of the seven legal codes. T and the reserved bits 27:8 never change through this port.
- R11: A status write with `psr_sel`=1 in a mode with a saved slot updates that slot's bits 31:28. It also updates bits 7:0, T included, when the written mode is legal. Bits 27:8 are kept. In user or system mode the write is ignored.
- R12: With no entry, `pc_load` and `lr_we` stay low. A return command, whenever present, suppresses a status write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| next_pc | input | ADDR_W | Address of the next instruction |
| ret_cmd | input | 1 | Return command: restore saved status |
| psr_we | input | 1 | Status write strobe |
| psr_sel | input | 1 | Write target: 0 current status, 1 saved status of current mode |
| psr_wdata | input | 32 | Status write data |
| pc_load | output | 1 | PC redirect valid pulse |
| pc_vec | output | ADDR_W | Exception vector address |
| lr_we | output | 1 | Link-register write valid pulse |
| lr_mode | output | 5 | Mode whose link register is written |
| lr_data | output | ADDR_W | Link value |
| psr_o | output | 32 | Current status word |
| spsr_o | output | 32 | Saved status of current mode, zero in user/system |
| mode_o | output | 5 | Current mode field |
| t_o | output | 1 | Instruction-set state bit |
| i_o | output | 1 | IRQ mask bit |
| f_o | output | 1 | FIQ mask bit |

## Verification
Every result of this block is due exactly one clock edge after the inputs that cause it. This covers the vector and link pulses, the new status word and the saved slot that an entry, return or write touches. The bench drives each stimulus on a falling edge, lets one rising edge pass, and compares all outputs on the next falling edge. It first updates its own mode, mask and saved-slot model with the same stimulus. Directed sequences cover reset release against a full set of requests, masked interrupts, return colliding with an abort, a saved write that sets T followed by a return, and writes attempted from user mode. A long seeded random run then mixes all inputs.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int PSR_W    = 32;
  localparam int NBANK    = 5;
  localparam int BANK_W   = $clog2(NBANK + 1);
  localparam int MODE_W   = 5;
  localparam int I_BIT    = 7;
  localparam int F_BIT    = 6;
  localparam int T_BIT    = 5;
  localparam int FLAG_LSB = 28;
  localparam logic [BANK_W-1:0] NO_BANK = '1;

  typedef enum logic [MODE_W-1:0] {
    M_USR = 5'h10, M_FIQ = 5'h11, M_IRQ = 5'h12, M_SVC = 5'h13,
    M_ABT = 5'h17, M_UND = 5'h1B, M_SYS = 5'h1F
  } mode_e;

  // class code order equals priority order (1 = highest)
  typedef enum logic [2:0] {
    X_NONE, X_RST, X_DABT, X_FIQ, X_IRQ, X_PABT, X_UND, X_SWI
  } exc_e;

  function automatic logic [MODE_W-1:0] target_mode(exc_e c);
    case (c)
      X_DABT, X_PABT: return M_ABT;
      X_FIQ:          return M_FIQ;
      X_IRQ:          return M_IRQ;
      X_UND:          return M_UND;
      default:        return M_SVC;
    endcase
  endfunction

  function automatic logic [7:0] vec_offset(exc_e c);
    case (c)
      X_UND:   return 8'h04;
      X_SWI:   return 8'h08;
      X_PABT:  return 8'h0C;
      X_DABT:  return 8'h10;
      X_IRQ:   return 8'h18;
      X_FIQ:   return 8'h1C;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic sets_f(exc_e c);
    return (c == X_RST) || (c == X_FIQ);
  endfunction

  function automatic logic mode_legal(logic [MODE_W-1:0] m);
    case (m)
      M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [BANK_W-1:0] bank_of(logic [MODE_W-1:0] m);
    case (m)
      M_FIQ:   return BANK_W'(0);
      M_IRQ:   return BANK_W'(1);
      M_SVC:   return BANK_W'(2);
      M_ABT:   return BANK_W'(3);
      M_UND:   return BANK_W'(4);
      default: return NO_BANK;
    endcase
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic boot,
  input  logic dabt,
  input  logic fiq,
  input  logic irq,
  input  logic pabt,
  input  logic und,
  input  logic swi,
  input  logic i_mask,
  input  logic f_mask,
  output exc_e cls
);
  localparam int NREQ = 7;

  logic [NREQ-1:0] live;

  // index 0 is the highest priority; index k maps to class k+1
  assign live = {swi, und, pabt, irq & ~i_mask, fiq & ~f_mask, dabt, boot};

  always_comb begin
    cls = X_NONE;
    for (int k = NREQ - 1; k >= 0; k--) begin
      if (live[k]) cls = exc_e'(3'(k + 1));
    end
  end
endmodule

// File: rtl/exc_psr_bank.sv
module exc_psr_bank
  import exc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  exc_e             cls,
  input  logic             ret_cmd,
  input  logic             psr_we,
  input  logic             psr_sel,
  input  logic [PSR_W-1:0] psr_wdata,
  output logic [PSR_W-1:0] cpsr_q,
  output logic [PSR_W-1:0] spsr_cur
);
  localparam logic [PSR_W-1:0] RESET_PSR =
    {{(PSR_W-8){1'b0}}, 1'b1, 1'b1, 1'b0, M_SVC};

  logic [NBANK-1:0][PSR_W-1:0] spsr_v;
  logic [BANK_W-1:0]           cur_bank;
  logic [BANK_W-1:0]           tgt_bank;
  logic                        take;
  logic                        cur_priv;
  logic [PSR_W-1:0]            cpsr_d;

  assign take     = (cls != X_NONE);
  assign cur_bank = bank_of(cpsr_q[MODE_W-1:0]);
  assign tgt_bank = bank_of(target_mode(cls));
  assign cur_priv = (cpsr_q[MODE_W-1:0] != M_USR);
  assign spsr_cur = (cur_bank < BANK_W'(NBANK)) ? spsr_v[cur_bank] : '0;

  always_comb begin
    cpsr_d = cpsr_q;
    if (take) begin
      cpsr_d[MODE_W-1:0] = target_mode(cls);
      cpsr_d[T_BIT]      = 1'b0;
      cpsr_d[I_BIT]      = 1'b1;
      if (sets_f(cls)) cpsr_d[F_BIT] = 1'b1;
    end else if (ret_cmd) begin
      if (cur_bank != NO_BANK) cpsr_d = spsr_cur;
    end else if (psr_we && !psr_sel) begin
      cpsr_d[PSR_W-1:FLAG_LSB] = psr_wdata[PSR_W-1:FLAG_LSB];
      if (cur_priv && mode_legal(psr_wdata[MODE_W-1:0])) begin
        cpsr_d[I_BIT]      = psr_wdata[I_BIT];
        cpsr_d[F_BIT]      = psr_wdata[F_BIT];
        cpsr_d[MODE_W-1:0] = psr_wdata[MODE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpsr_q <= RESET_PSR;
    else        cpsr_q <= cpsr_d;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             cap;
    logic             sw;
    logic [PSR_W-1:0] sw_d;
    logic [PSR_W-1:0] val_q;

    assign cap = take && (tgt_bank == BANK_W'(b));
    assign sw  = !take && !ret_cmd && psr_we && psr_sel &&
                 (cur_bank == BANK_W'(b));

    always_comb begin
      sw_d = val_q;
      sw_d[PSR_W-1:FLAG_LSB] = psr_wdata[PSR_W-1:FLAG_LSB];
      if (mode_legal(psr_wdata[MODE_W-1:0])) sw_d[7:0] = psr_wdata[7:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (cap) val_q <= cpsr_q;
      else if (sw)  val_q <= sw_d;
    end

    assign spsr_v[b] = val_q;
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_dabt,
  input  logic              req_fiq,
  input  logic              req_irq,
  input  logic              req_pabt,
  input  logic              req_und,
  input  logic              req_swi,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic              ret_cmd,
  input  logic              psr_we,
  input  logic              psr_sel,
  input  logic [PSR_W-1:0]  psr_wdata,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_vec,
  output logic              lr_we,
  output logic [MODE_W-1:0] lr_mode,
  output logic [ADDR_W-1:0] lr_data,
  output logic [PSR_W-1:0]  psr_o,
  output logic [PSR_W-1:0]  spsr_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              t_o,
  output logic              i_o,
  output logic              f_o
);
  exc_e             cls;
  logic             boot_q;
  logic             take;
  logic [PSR_W-1:0] cpsr;
  logic [PSR_W-1:0] spsr;

  exc_arbiter u_arb (
    .boot   (boot_q),
    .dabt   (req_dabt),
    .fiq    (req_fiq),
    .irq    (req_irq),
    .pabt   (req_pabt),
    .und    (req_und),
    .swi    (req_swi),
    .i_mask (cpsr[I_BIT]),
    .f_mask (cpsr[F_BIT]),
    .cls    (cls)
  );

  exc_psr_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cls       (cls),
    .ret_cmd   (ret_cmd),
    .psr_we    (psr_we),
    .psr_sel   (psr_sel),
    .psr_wdata (psr_wdata),
    .cpsr_q    (cpsr),
    .spsr_cur  (spsr)
  );

  assign take = (cls != X_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q  <= 1'b1;
      pc_load <= 1'b0;
      pc_vec  <= VEC_BASE;
      lr_we   <= 1'b0;
      lr_mode <= M_SVC;
      lr_data <= '0;
    end else begin
      boot_q  <= 1'b0;
      pc_load <= take;
      lr_we   <= take;
      if (take) begin
        pc_vec  <= VEC_BASE + ADDR_W'(vec_offset(cls));
        lr_mode <= target_mode(cls);
        lr_data <= next_pc;
      end
    end
  end

  assign psr_o  = cpsr;
  assign spsr_o = spsr;
  assign mode_o = cpsr[MODE_W-1:0];
  assign t_o    = cpsr[T_BIT];
  assign i_o    = cpsr[I_BIT];
  assign f_o    = cpsr[F_BIT];
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              boot,
  input logic              req_dabt,
  input logic              req_fiq,
  input logic              req_irq,
  input logic              req_pabt,
  input logic              req_und,
  input logic              req_swi,
  input logic              ret_cmd,
  input logic              pc_load,
  input logic [ADDR_W-1:0] pc_vec,
  input logic [4:0]        lr_mode,
  input logic [31:0]       psr,
  input logic [31:0]       spsr
);
  logic any_req;
  assign any_req = req_dabt | req_fiq | req_irq | req_pabt | req_und | req_swi;

  // R1
  boot_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot |=> (pc_load && pc_vec == VEC_BASE && lr_mode == 5'h13));

  // R3
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot && req_irq && psr[7] && !req_dabt && !req_fiq && !req_pabt &&
     !req_und && !req_swi) |=> !pc_load);

  // R6
  entry_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (!psr[5] && psr[7] && psr[4:0] == lr_mode));

  // R7
  fiq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && lr_mode == 5'h11) |-> pc_vec == VEC_BASE + ADDR_W'(8'h1C));

  // R7
  irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && lr_mode == 5'h12) |-> pc_vec == VEC_BASE + ADDR_W'(8'h18));

  // R8
  return_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_cmd && !boot && !any_req && psr[4:0] != 5'h10 && psr[4:0] != 5'h1F)
      |=> psr == $past(spsr));

  // R10
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psr[27:8] == 20'h0);
endmodule

bind exc_ctrl exc_ctrl_chk #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .boot     (boot_q),
  .req_dabt (req_dabt),
  .req_fiq  (req_fiq),
  .req_irq  (req_irq),
  .req_pabt (req_pabt),
  .req_und  (req_und),
  .req_swi  (req_swi),
  .ret_cmd  (ret_cmd),
  .pc_load  (pc_load),
  .pc_vec   (pc_vec),
  .lr_mode  (lr_mode),
  .psr      (psr_o),
  .spsr     (spsr_o)
);

// File: tb/exc_ctrl_tb_top.sv
module exc_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_dabt = 0, req_fiq = 0, req_irq = 0, req_pabt = 0, req_und = 0, req_swi = 0;
  logic [31:0] next_pc = '0;
  logic        ret_cmd = 0, psr_we = 0, psr_sel = 0;
  logic [31:0] psr_wdata = '0;
  logic        pc_load, lr_we, t_o, i_o, f_o;
  logic [31:0] pc_vec, lr_data, psr_o, spsr_o;
  logic [4:0]  lr_mode, mode_o;

  int n_chk = 0;
  int n_fail = 0;
  logic        m_boot;
  logic [31:0] m_cpsr;
  logic [31:0] m_spsr [5];

  always #5 clk = ~clk;

  exc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_dabt(req_dabt), .req_fiq(req_fiq), .req_irq(req_irq),
    .req_pabt(req_pabt), .req_und(req_und), .req_swi(req_swi),
    .next_pc(next_pc), .ret_cmd(ret_cmd), .psr_we(psr_we),
    .psr_sel(psr_sel), .psr_wdata(psr_wdata),
    .pc_load(pc_load), .pc_vec(pc_vec), .lr_we(lr_we), .lr_mode(lr_mode),
    .lr_data(lr_data), .psr_o(psr_o), .spsr_o(spsr_o), .mode_o(mode_o),
    .t_o(t_o), .i_o(i_o), .f_o(f_o)
  );

  // class codes: 1 reset, 2 dabt, 3 fiq, 4 irq, 5 pabt, 6 und, 7 swi
  function automatic logic [4:0] b_mode(int c);
    case (c)
      2, 5: return 5'h17;
      3:    return 5'h11;
      4:    return 5'h12;
      6:    return 5'h1B;
      default: return 5'h13;
    endcase
  endfunction

  function automatic logic [31:0] b_vec(int c);
    case (c)
      2: return 32'h10;
      3: return 32'h1C;
      4: return 32'h18;
      5: return 32'h0C;
      6: return 32'h04;
      7: return 32'h08;
      default: return 32'h00;
    endcase
  endfunction

  function automatic int b_bank(logic [4:0] m);
    case (m)
      5'h11: return 0;
      5'h12: return 1;
      5'h13: return 2;
      5'h17: return 3;
      5'h1B: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic logic b_legal(logic [4:0] m);
    return m inside {5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // r: {swi, und, pabt, irq, fiq, dabt}
  task automatic cyc(logic [5:0] r, logic ret, logic we, logic sel,
                     logic [31:0] wd, logic [31:0] npc);
    logic [6:0]  live;
    int          cls;
    int          nlive;
    int          bk;
    logic        masked;
    logic [31:0] exp_sp;
    string       t_load, t_psr, t_sp, t_vec;
    req_dabt = r[0]; req_fiq = r[1]; req_irq = r[2];
    req_pabt = r[3]; req_und = r[4]; req_swi = r[5];
    ret_cmd = ret; psr_we = we; psr_sel = sel; psr_wdata = wd; next_pc = npc;

    live = {r[5], r[4], r[3], r[2] & ~m_cpsr[7], r[1] & ~m_cpsr[6], r[0], m_boot};
    masked = (r[1] && m_cpsr[6]) || (r[2] && m_cpsr[7]);
    cls = 0;
    nlive = 0;
    for (int k = 6; k >= 0; k--) begin
      if (live[k]) begin cls = k + 1; nlive++; end
    end
    bk = b_bank(m_cpsr[4:0]);
    if (cls != 0) begin
      m_spsr[b_bank(b_mode(cls))] = m_cpsr;
      m_cpsr[4:0] = b_mode(cls);
      m_cpsr[5] = 1'b0;
      m_cpsr[7] = 1'b1;
      if (cls == 1 || cls == 3) m_cpsr[6] = 1'b1;
      t_load = (cls == 1) ? "R1" : (nlive > 1) ? "R2" : "R4";
      t_psr  = ret ? "R9" : "R6";
      t_sp   = "R5";
    end else begin
      t_load = masked ? "R3" : "R12";
      t_sp   = "R8";
      if (ret) begin
        t_psr = "R8";
        if (bk >= 0) m_cpsr = m_spsr[bk];
      end else if (we && !sel) begin
        t_psr = "R10";
        m_cpsr[31:28] = wd[31:28];
        if (m_cpsr[4:0] != 5'h10 && b_legal(wd[4:0])) begin
          m_cpsr[7:6] = wd[7:6];
          m_cpsr[4:0] = wd[4:0];
        end
      end else if (we && sel) begin
        t_psr = "R11";
        t_sp  = "R11";
        if (bk >= 0) begin
          m_spsr[bk][31:28] = wd[31:28];
          if (b_legal(wd[4:0])) m_spsr[bk][7:0] = wd[7:0];
        end
      end else begin
        t_psr = masked ? "R3" : "R12";
      end
    end
    m_boot = 1'b0;
    bk = b_bank(m_cpsr[4:0]);
    exp_sp = (bk >= 0) ? m_spsr[bk] : 32'h0;
    t_vec = (cls == 1) ? "R1" : "R7";

    @(posedge clk);
    @(negedge clk);
    chk(t_load, {31'b0, pc_load}, {31'b0, cls != 0});
    chk(t_load, {31'b0, lr_we},   {31'b0, cls != 0});
    if (cls != 0) begin
      chk(t_vec, pc_vec, b_vec(cls));
      chk("R4", {27'b0, lr_mode}, {27'b0, b_mode(cls)});
      chk("R4", lr_data, npc);
    end
    chk(t_psr, psr_o, m_cpsr);
    chk(t_sp, spsr_o, exp_sp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R12 watchdog expired got 0 exp 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [5:0]  r;
    logic [4:0]  md;
    logic [31:0] wd;
    void'($urandom(32'd20250));
    m_cpsr = 32'h0000_00D3;
    for (int b = 0; b < 5; b++) m_spsr[b] = '0;
    m_boot = 1'b1;

    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk("R1", psr_o, 32'h0000_00D3);
    chk("R1", {31'b0, pc_load}, 32'h0);
    chk("R1", spsr_o, 32'h0);
    rst_n = 1'b1;

    cyc(6'h3F, 1'b1, 1'b0, 1'b0, '0, 32'h0000_1000);       // R1 reset beats all
    cyc(6'h3F, 1'b0, 1'b0, 1'b0, '0, 32'h0000_2004);       // R2 dabt wins, fiq/irq masked
    cyc(6'h00, 1'b0, 1'b1, 1'b0, 32'hF000_0017, 32'h0);    // R10 clear I and F
    cyc(6'h0E, 1'b0, 1'b0, 1'b0, '0, 32'h0000_3008);       // R2 fiq over irq, pabt
    cyc(6'h08, 1'b1, 1'b0, 1'b0, '0, 32'h0000_400C);       // R9 pabt beats return
    cyc(6'h00, 1'b1, 1'b0, 1'b0, '0, 32'h0);               // R8 back to fiq state
    cyc(6'h00, 1'b0, 1'b1, 1'b1, 32'h5ABC_DE30, 32'h0);    // R11 saved: usr, T set
    cyc(6'h00, 1'b1, 1'b0, 1'b0, '0, 32'h0);               // R8 restores T
    cyc(6'h00, 1'b1, 1'b0, 1'b0, '0, 32'h0);               // R8 ignored in user
    cyc(6'h00, 1'b0, 1'b1, 1'b0, 32'h8000_0013, 32'h0);    // R10 control ignored in user
    cyc(6'h00, 1'b0, 1'b1, 1'b1, 32'h7000_0013, 32'h0);    // R11 ignored in user
    cyc(6'h20, 1'b0, 1'b0, 1'b0, '0, 32'h0000_5010);       // R6 swi from user
    cyc(6'h04, 1'b0, 1'b0, 1'b0, '0, 32'h0000_6014);       // R3 irq masked
    cyc(6'h10, 1'b0, 1'b1, 1'b0, 32'hFFFF_FF1F, 32'h0000_7018); // R12 und beats write

    for (int n = 0; n < 4000; n++) begin
      for (int k = 0; k < 6; k++) r[k] = ($urandom % 14) == 0;
      case ($urandom % 8)
        0: md = 5'h10;
        1: md = 5'h11;
        2: md = 5'h12;
        3: md = 5'h13;
        4: md = 5'h17;
        5: md = 5'h1B;
        6: md = 5'h1F;
        default: md = 5'($urandom);
      endcase
      wd = $urandom;
      wd[4:0] = md;
      cyc(r, ($urandom % 6) == 0, ($urandom % 3) == 0, $urandom % 2 == 1, wd, $urandom);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule